// File: doc/BRIEF.md
# Banked SRAM Crossbar with Round-Robin Arbitration

This block sits between a few bus masters (an instruction fetch port, a data port and a DMA engine, say) and a memory region made of eight SRAM banks of unequal size. The banks fill the region end to end with no gaps. Each master drives a request with address, write flag, write data and byte enables. The block grants the request in the same cycle and returns an acknowledge with read data one cycle later.

The same bytes can be reached through three address windows, at 0x2000_0000, 0x0010_0000 and 0x3000_0000. Each bank has its own arbiter, so masters that target different banks are served in the same cycle. When several masters collide on one bank, the grant rotates among them.

Each bank has a power-state input. Only full power lets an access reach the bank. An access to a bank in retention or off is acknowledged at once with an error and changes nothing. A bank in retention keeps its contents. A bank that is switched off has its contents replaced by a fixed poison word.

Bank sizes are set in multiples of a unit, `UNIT_BYTES`. A value of 32768 gives the full 512 KB map. The default of 64 bytes keeps the storage small while the layout stays the same.

Top module: `sramx_xbar`

## Requirements
- R1: A byte offset within the region reaches the same storage through all three windows (bases 0x2000_0000, 0x0010_0000, 0x3000_0000).
- R2: The bank is chosen by comparing the offset against unit boundaries 0, 1, 2, 3, 4, 6, 8, 12 and 16 (times `UNIT_BYTES`), giving banks 0..7 in ascending order.
- R3: An address outside every window is granted in the cycle it is presented, acknowledged with `m_err`=1, and writes nothing.
- R4: Masters whose requests target different full-power banks are all granted in the same cycle. A grant is never given without a request.
- R5: Each bank grants at most one master per cycle. It picks the first requester at or after its pointer, counting upward and wrapping. The pointer then moves to the master after the winner. After reset every pointer is at master 0.
- R6: `m_done` rises exactly one cycle after a grant and at no other time. For a read without error, `m_rdata` holds the addressed word in that same cycle.
- R7: Byte enable bit k writes bits 8k+7..8k of the word. Bytes whose enable is 0 keep their value.
- R8: Bank power codes are 0 = full, 1 = retention, 2 = off (3 is treated as off). An access to a bank that is not at full power gets `m_err`=1 and has no effect. A bank in retention keeps its contents.
- R9: While a bank is off, every word in it is overwritten with the poison word 0xDEADBEEF. That value is what is read once the bank is back at full power.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | NM | Request, one bit per master |
| m_we | input | NM | Write (1) or read (0), per master |
| m_addr | input | NM*32 | Byte address, master m in bits 32m+31..32m |
| m_wdata | input | NM*32 | Write data per master |
| m_be | input | NM*4 | Byte enables per master |
| bank_pwr | input | 16 | Two-bit power code per bank, bank b in bits 2b+1..2b |
| m_gnt | output | NM | Grant this cycle, per master |
| m_done | output | NM | Acknowledge, one cycle after grant |
| m_err | output | NM | Error flag, valid with m_done |
| m_rdata | output | NM*32 | Read data, valid with m_done |

## Verification
A round-robin pointer left at the wrong master shows up at once as the wrong grant in the next collision cycle. A decode error puts data in the wrong bank, and this is seen later as a read mismatch against the reference memory, through another window or at a bank boundary. A wrong power gate shows up in the acknowledge cycle as a missing or spurious error flag. A lost or retained word is caught by the first read after the bank returns to full power. A broken latency path misplaces `m_done` by a cycle relative to the grant.

// File: rtl/sramx_pkg.sv
package sramx_pkg;

    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int BEW    = DW / 8;
    localparam int NB     = 8;
    localparam int BANK_W = $clog2(NB);
    localparam int NWIN   = 3;

    typedef enum logic [1:0] {
        PWR_FULL = 2'd0,
        PWR_RET  = 2'd1,
        PWR_OFF  = 2'd2
    } pwr_e;

    // Size of each bank in units; ascending address order.
    function automatic int unsigned bank_units(int b);
        case (b)
            0, 1, 2, 3: return 1;
            4, 5:       return 2;
            default:    return 4;
        endcase
    endfunction

    // Unit offset where bank b starts (b == NB gives the total).
    function automatic int unsigned bank_first(int b);
        int unsigned s;
        s = 0;
        for (int i = 0; i < b; i++) s += bank_units(i);
        return s;
    endfunction

    function automatic logic [AW-1:0] win_base(int w);
        case (w)
            0:       return 32'h2000_0000;
            1:       return 32'h0010_0000;
            default: return 32'h3000_0000;
        endcase
    endfunction

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [AW-1:0]     word;
    } dec_t;

    typedef struct packed {
        logic           we;
        logic [AW-1:0]  word;
        logic [DW-1:0]  wdata;
        logic [BEW-1:0] be;
    } bank_cmd_t;

endpackage

// File: rtl/sramx_decode.sv
module sramx_decode import sramx_pkg::*; #(
    parameter int unsigned UNIT_BYTES = 64
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int unsigned TOTAL_UNITS = bank_first(NB);
    localparam logic [AW-1:0] SPAN = AW'(TOTAL_UNITS * UNIT_BYTES);

    logic [AW-1:0] off;
    logic [AW-1:0] rel;
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;

    always_comb begin
        dec = '0;
        off = '0;
        rel = '0;
        lo  = '0;
        hi  = '0;
        // window match: unsigned wrap makes addresses below a base miss
        for (int w = 0; w < NWIN; w++) begin
            rel = addr - win_base(w);
            if (rel < SPAN) begin
                dec.hit = 1'b1;
                off     = rel;
            end
        end
        // bank select by range compare on the window offset
        for (int b = 0; b < NB; b++) begin
            lo = AW'(bank_first(b) * UNIT_BYTES);
            hi = AW'((bank_first(b) + bank_units(b)) * UNIT_BYTES);
            if (off >= lo && off < hi) begin
                dec.bank = BANK_W'(b);
                dec.word = (off - lo) >> 2;
            end
        end
    end
endmodule

// File: rtl/sramx_rr.sv
module sramx_rr #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic [PW-1:0] win;
    logic          found;
    int            idx;

    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        idx   = 0;
        for (int i = 0; i < N; i++) begin
            idx = int'(ptr) + i;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (found)
            ptr <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
    end
endmodule

// File: rtl/sramx_bank.sv
module sramx_bank import sramx_pkg::*; #(
    parameter int          WORDS  = 16,
    parameter logic [31:0] POISON = 32'hDEAD_BEEF
) (
    input  logic          clk,
    input  logic          en,
    input  bank_cmd_t     cmd,
    input  logic          wipe,
    output logic [DW-1:0] rdata
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [DW-1:0] mem [WORDS];
    logic [IW-1:0] idx;
    logic          unused_hi;

    assign idx       = cmd.word[IW-1:0];
    assign unused_hi = ^cmd.word[AW-1:IW];

    always_ff @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= POISON;
        end else if (en) begin
            if (cmd.we) begin
                for (int j = 0; j < BEW; j++)
                    if (cmd.be[j]) mem[idx][8*j +: 8] <= cmd.wdata[8*j +: 8];
            end else begin
                rdata <= mem[idx];
            end
        end
    end
endmodule

// File: rtl/sramx_xbar.sv
module sramx_xbar import sramx_pkg::*; #(
    parameter int          NM         = 3,
    parameter int unsigned UNIT_BYTES = 64,
    parameter logic [31:0] POISON     = 32'hDEAD_BEEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NM-1:0]    m_req,
    input  logic [NM-1:0]    m_we,
    input  logic [NM*AW-1:0] m_addr,
    input  logic [NM*DW-1:0] m_wdata,
    input  logic [NM*BEW-1:0] m_be,
    input  logic [2*NB-1:0]  bank_pwr,
    output logic [NM-1:0]    m_gnt,
    output logic [NM-1:0]    m_done,
    output logic [NM-1:0]    m_err,
    output logic [NM*DW-1:0] m_rdata
);
    dec_t              dec      [NM];
    logic [NB-1:0]     full;
    logic [NB-1:0]     wipe;
    logic [NM-1:0]     want     [NB];
    logic [NM-1:0]     bgnt     [NB];
    logic [DW-1:0]     bank_rd  [NB];
    logic [NM-1:0]     bad;
    logic [NM-1:0]     err_q;
    logic [NM-1:0]     done_q;
    logic [BANK_W-1:0] sel_q    [NM];
    logic [NB*NM-1:0]  bgnt_flat;

    // per-master address decode
    for (genvar m = 0; m < NM; m++) begin : g_dec
        sramx_decode #(.UNIT_BYTES(UNIT_BYTES)) u_dec (
            .addr (m_addr[m*AW +: AW]),
            .dec  (dec[m])
        );
    end

    // power state per bank
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            full[b] = (bank_pwr[2*b +: 2] == PWR_FULL);
            wipe[b] = !full[b] && (bank_pwr[2*b +: 2] != PWR_RET);
        end
    end

    // request steering: valid work goes to a bank, the rest to the error path
    always_comb begin
        for (int b = 0; b < NB; b++)
            for (int m = 0; m < NM; m++)
                want[b][m] = m_req[m] && dec[m].hit
                             && (dec[m].bank == BANK_W'(b)) && full[b];
        for (int m = 0; m < NM; m++)
            bad[m] = m_req[m] && !(dec[m].hit && full[dec[m].bank]);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bank_cmd_t cmd;

        sramx_rr #(.N(NM)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (want[b]),
            .gnt (bgnt[b])
        );

        always_comb begin
            cmd = '0;
            for (int m = 0; m < NM; m++)
                if (bgnt[b][m])
                    cmd = '{we:    m_we[m],
                            word:  dec[m].word,
                            wdata: m_wdata[m*DW +: DW],
                            be:    m_be[m*BEW +: BEW]};
        end

        sramx_bank #(
            .WORDS  (int'(bank_units(b) * UNIT_BYTES / 4)),
            .POISON (POISON)
        ) u_mem (
            .clk   (clk),
            .en    (|bgnt[b]),
            .cmd   (cmd),
            .wipe  (wipe[b]),
            .rdata (bank_rd[b])
        );

        assign bgnt_flat[b*NM +: NM] = bgnt[b];
    end

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_gnt[m] = bad[m];
            for (int b = 0; b < NB; b++) m_gnt[m] = m_gnt[m] | bgnt[b][m];
        end
    end

    // response stage: one cycle after grant
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
            err_q  <= '0;
            for (int m = 0; m < NM; m++) sel_q[m] <= '0;
        end else begin
            done_q <= m_gnt;
            err_q  <= bad;
            for (int m = 0; m < NM; m++)
                if (m_gnt[m]) sel_q[m] <= dec[m].bank;
        end
    end

    assign m_done = done_q;
    assign m_err  = err_q;

    always_comb begin
        for (int m = 0; m < NM; m++)
            m_rdata[m*DW +: DW] = err_q[m] ? '0 : bank_rd[sel_q[m]];
    end
endmodule

// File: rtl/sramx_xbar_chk.sv
module sramx_xbar_chk #(
    parameter int NM = 3,
    parameter int NB = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NM-1:0]    m_req,
    input logic [NM-1:0]    m_gnt,
    input logic [NM-1:0]    m_done,
    input logic [2*NB-1:0]  bank_pwr,
    input logic [NB*NM-1:0] bank_gnt
);
    for (genvar m = 0; m < NM; m++) begin : g_m
        // R6
        ack_follows_gnt_chk: assert property (@(posedge clk) disable iff (rst)
            (m_req[m] && m_gnt[m]) |=> m_done[m]);
        // R6
        no_stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
            !m_gnt[m] |=> !m_done[m]);
        // R4
        gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
            m_gnt[m] |-> m_req[m]);
    end

    for (genvar b = 0; b < NB; b++) begin : g_b
        // R5
        one_winner_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(bank_gnt[b*NM +: NM]));
        // R8
        unpowered_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (bank_pwr[2*b +: 2] != 2'd0) |-> (bank_gnt[b*NM +: NM] == '0));
    end
endmodule

bind sramx_xbar sramx_xbar_chk #(.NM(NM)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .m_req    (m_req),
    .m_gnt    (m_gnt),
    .m_done   (m_done),
    .bank_pwr (bank_pwr),
    .bank_gnt (bgnt_flat)
);

// File: tb/sramx_xbar_test.sv
module sramx_xbar_test;
    import sramx_pkg::*;

    localparam int CLK_P = 10;
    localparam int NMT   = 3;
    localparam int RB    = 1024;
    localparam int RW    = RB / 4;
    localparam logic [31:0] POIS = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic [NMT-1:0]    req = '0;
    logic [NMT-1:0]    we  = '0;
    logic [NMT*32-1:0] addr = '0;
    logic [NMT*32-1:0] wd   = '0;
    logic [NMT*4-1:0]  be   = '0;
    logic [15:0]       pwr  = '0;
    logic [NMT-1:0]    gnt;
    logic [NMT-1:0]    done;
    logic [NMT-1:0]    err;
    logic [NMT*32-1:0] rdata;

    sramx_xbar #(.NM(NMT), .UNIT_BYTES(64)) uut (
        .clk(clk), .rst(rst), .m_req(req), .m_we(we), .m_addr(addr),
        .m_wdata(wd), .m_be(be), .bank_pwr(pwr), .m_gnt(gnt),
        .m_done(done), .m_err(err), .m_rdata(rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] ref_mem [RW];
    logic [1:0]  bpwr [8];

    bit          pend [NMT];
    bit          p_we [NMT];
    logic [31:0] p_addr [NMT];
    logic [31:0] p_wd [NMT];
    logic [3:0]  p_be [NMT];
    bit          x_err [NMT];
    logic [31:0] x_rd [NMT];
    int          g_iter [NMT];
    logic [31:0] got [NMT];

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic int bank_lo(int b);
        case (b)
            0: return 0;    1: return 64;   2: return 128;  3: return 192;
            4: return 256;  5: return 384;  6: return 512;  7: return 768;
            default: return RB;
        endcase
    endfunction

    function automatic int bank_of(int off);
        for (int b = 0; b < 8; b++)
            if (off >= bank_lo(b) && off < bank_lo(b + 1)) return b;
        return 0;
    endfunction

    function automatic int win_off(logic [31:0] a);
        if (a >= 32'h2000_0000 && a < 32'h2000_0000 + RB) return int'(a - 32'h2000_0000);
        if (a >= 32'h0010_0000 && a < 32'h0010_0000 + RB) return int'(a - 32'h0010_0000);
        if (a >= 32'h3000_0000 && a < 32'h3000_0000 + RB) return int'(a - 32'h3000_0000);
        return -1;
    endfunction

    function automatic logic [31:0] base_of(int w);
        case (w)
            0: return 32'h2000_0000;
            1: return 32'h0010_0000;
            default: return 32'h3000_0000;
        endcase
    endfunction

    task automatic set_pwr(int b, logic [1:0] s);
        bpwr[b] = s;
        pwr[2*b +: 2] = s;
        if (s >= 2)
            for (int i = bank_lo(b) / 4; i < bank_lo(b + 1) / 4; i++) ref_mem[i] = POIS;
    endtask

    task automatic post(int m, bit w, logic [31:0] a, logic [31:0] d, logic [3:0] b);
        pend[m] = 1'b1; p_we[m] = w; p_addr[m] = a; p_wd[m] = d; p_be[m] = b;
    endtask

    task automatic model(int m);
        int off;
        int wi;
        off = win_off(p_addr[m]);
        if (off < 0 || bpwr[bank_of(off)] != 2'd0) begin
            x_err[m] = 1'b1;
        end else begin
            x_err[m] = 1'b0;
            wi = off / 4;
            if (p_we[m]) begin
                for (int k = 0; k < 4; k++)
                    if (p_be[m][k]) ref_mem[wi][8*k +: 8] = p_wd[m][8*k +: 8];
            end else begin
                x_rd[m] = ref_mem[wi];
            end
        end
    endtask

    task automatic run(string tag);
        int it;
        logic [NMT-1:0] gs;
        it = 0;
        for (int m = 0; m < NMT; m++) g_iter[m] = -1;
        @(negedge clk);
        while ((pend[0] || pend[1] || pend[2]) && it < 40) begin
            for (int m = 0; m < NMT; m++) begin
                req[m] = pend[m];
                we[m]  = p_we[m];
                addr[m*32 +: 32] = p_addr[m];
                wd[m*32 +: 32]   = p_wd[m];
                be[m*4 +: 4]     = p_be[m];
            end
            #(CLK_P/4);
            gs = gnt;
            for (int m = 0; m < NMT; m++)
                if (gs[m] && pend[m]) begin
                    g_iter[m] = it;
                    model(m);
                end
            @(negedge clk);
            for (int m = 0; m < NMT; m++) begin
                check(done[m] == gs[m], $sformatf("R6 ack timing m%0d", m), 32'(done[m]), 32'(gs[m]));
                if (gs[m] && pend[m]) begin
                    check(err[m] == x_err[m], $sformatf("%s err m%0d", tag, m), 32'(err[m]), 32'(x_err[m]));
                    got[m] = rdata[m*32 +: 32];
                    if (!p_we[m] && !x_err[m])
                        check(got[m] === x_rd[m], $sformatf("%s rdata m%0d", tag, m), got[m], x_rd[m]);
                    pend[m] = 1'b0;
                end
            end
            it++;
        end
        for (int m = 0; m < NMT; m++)
            if (pend[m]) begin
                check(1'b0, $sformatf("R5 starved m%0d", m), 32'(it), 32'd0);
                pend[m] = 1'b0;
            end
        req = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int off;
        logic [NMT-1:0] exp_g;
        process::self().srandom(32'd1234);
        for (int b = 0; b < 8; b++) bpwr[b] = 2'd0;
        for (int m = 0; m < NMT; m++) pend[m] = 1'b0;
        for (int i = 0; i < RW; i++) ref_mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #(CLK_P/4);
        check(done == '0 && err == '0 && gnt == '0, "R6 reset state", {29'd0, done}, 32'd0);

        // R5: three-way collision on bank 0, pointer starts at master 0
        @(negedge clk);
        req = 3'b111; we = '0; addr = {3{32'h2000_0000}};
        for (int c = 0; c < 9; c++) begin
            #(CLK_P/4);
            exp_g = 3'b001 << (c % 3);
            check(gnt == exp_g, "R5 rotation of three", 32'(gnt), 32'(exp_g));
            @(negedge clk);
        end
        // R5: masters 0 and 2 only, pointer now at master 0
        req = 3'b101;
        for (int c = 0; c < 6; c++) begin
            #(CLK_P/4);
            exp_g = (c % 2 == 0) ? 3'b001 : 3'b100;
            check(gnt == exp_g, "R5 rotation of two", 32'(gnt), 32'(exp_g));
            @(negedge clk);
        end
        req = '0;
        @(negedge clk);

        // fill the region
        for (int w = 0; w < RW; w += 3) begin
            for (int m = 0; m < NMT; m++)
                if (w + m < RW)
                    post(m, 1'b1, base_of($urandom_range(0, 2)) + 32'((w + m) * 4), $urandom, 4'hF);
            run("R1 fill");
        end

        // R1: write through one alias, read through the other two
        post(0, 1'b1, 32'h0010_01A0, 32'hA5A5_5A5A, 4'hF);
        run("R1");
        post(1, 1'b0, 32'h3000_01A0, 32'h0, 4'hF);
        post(2, 1'b0, 32'h2000_01A0, 32'h0, 4'hF);
        run("R1");
        check(got[1] == 32'hA5A5_5A5A && got[2] == 32'hA5A5_5A5A, "R1 alias data", got[1], 32'hA5A5_5A5A);

        // R7: byte lanes
        post(0, 1'b1, 32'h2000_0010, 32'h1122_3344, 4'hF);  run("R7");
        post(0, 1'b1, 32'h2000_0010, 32'hAAAA_AAAA, 4'b0001); run("R7");
        post(0, 1'b1, 32'h2000_0010, 32'hBBBB_BBBB, 4'b0100); run("R7");
        post(0, 1'b1, 32'h2000_0010, 32'hCCCC_DDDD, 4'b1100); run("R7");
        post(0, 1'b1, 32'h2000_0010, 32'h0000_EEFF, 4'b0011); run("R7");
        post(0, 1'b0, 32'h3000_0010, 32'h0, 4'hF); run("R7");
        check(got[0] == 32'hCCCC_EEFF, "R7 merged word", got[0], 32'hCCCC_EEFF);

        // R4: three different banks in one cycle
        post(0, 1'b0, 32'h2000_0000, 32'h0, 4'hF);
        post(1, 1'b0, 32'h0010_0180, 32'h0, 4'hF);
        post(2, 1'b1, 32'h3000_0310, 32'h600D_F00D, 4'hF);
        run("R4");
        for (int m = 0; m < NMT; m++)
            check(g_iter[m] == 0, $sformatf("R4 parallel grant m%0d", m), 32'(g_iter[m]), 32'd0);

        // R3: outside every window
        post(0, 1'b0, 32'h2000_0400, 32'h0, 4'hF);
        post(1, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 4'hF);
        post(2, 1'b1, 32'h1FFF_FFFC, 32'hFFFF_FFFF, 4'hF);
        run("R3");
        for (int m = 0; m < NMT; m++)
            check(g_iter[m] == 0, $sformatf("R3 immediate grant m%0d", m), 32'(g_iter[m]), 32'd0);
        post(0, 1'b0, 32'h2000_03FC, 32'h0, 4'hF);
        post(1, 1'b0, 32'h2000_0000, 32'h0, 4'hF);
        run("R3 no side effect");

        // R2 / R8: banks 4 and 7 in retention, probe the edges
        @(negedge clk);
        set_pwr(4, 2'd1);
        set_pwr(7, 2'd1);
        post(0, 1'b0, 32'h2000_00FC, 32'h0, 4'hF);
        post(1, 1'b1, 32'h2000_0100, 32'h1234_5678, 4'hF);
        post(2, 1'b0, 32'h2000_017C, 32'h0, 4'hF);
        run("R2");
        post(0, 1'b0, 32'h2000_0180, 32'h0, 4'hF);
        post(1, 1'b0, 32'h2000_02FC, 32'h0, 4'hF);
        post(2, 1'b1, 32'h2000_0300, 32'h1234_5678, 4'hF);
        run("R2");
        post(0, 1'b0, 32'h2000_03FC, 32'h0, 4'hF);
        run("R2");
        @(negedge clk);
        set_pwr(4, 2'd0);
        set_pwr(7, 2'd0);
        post(1, 1'b0, 32'h2000_0100, 32'h0, 4'hF);
        post(2, 1'b0, 32'h2000_0300, 32'h0, 4'hF);
        run("R8 retained");
        check(got[1] != 32'h1234_5678, "R8 blocked write", got[1], ref_mem[64]);

        // R9: bank 1 off, then back on
        @(negedge clk);
        set_pwr(1, 2'd2);
        repeat (2) @(negedge clk);
        post(0, 1'b0, 32'h2000_0040, 32'h0, 4'hF);
        run("R8 off");
        @(negedge clk);
        set_pwr(1, 2'd0);
        post(0, 1'b0, 32'h2000_0040, 32'h0, 4'hF);
        post(1, 1'b0, 32'h0010_007C, 32'h0, 4'hF);
        run("R9");
        check(got[0] == POIS && got[1] == POIS, "R9 poison", got[0], POIS);

        // random mixed traffic through all windows
        for (int t = 0; t < 400; t++) begin
            bit collide;
            collide = ($urandom_range(0, 3) == 0);
            for (int m = 0; m < NMT; m++) begin
                logic [3:0] bsel;
                logic [31:0] a;
                if ($urandom_range(0, 9) < 8) begin
                    off = collide ? 512 + 4 * $urandom_range(0, 63) : 4 * $urandom_range(0, RW - 1);
                    a = base_of($urandom_range(0, 2)) + 32'(off);
                    if ($urandom_range(0, 19) == 0) a = 32'h2000_0400 + 32'(4 * $urandom_range(0, 15));
                    case ($urandom_range(0, 6))
                        0: bsel = 4'b0001; 1: bsel = 4'b0010; 2: bsel = 4'b0100;
                        3: bsel = 4'b1000; 4: bsel = 4'b0011; 5: bsel = 4'b1100;
                        default: bsel = 4'b1111;
                    endcase
                    post(m, 1'($urandom_range(0, 1)), a, $urandom, bsel);
                end
            end
            run(collide ? "R5 random" : "R2 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule